// File: doc/BRIEF.md
# Interrupt Status and Open-Drain Flag Controller

This block gathers the event sources of a small LED driver chip into one status byte and drives the chip's active-low interrupt line. There are six sources: power-on reset, undervoltage, overtemperature, and a pattern-done event from each of the LED channels. Every flag is sticky. It stays set until software reads the status byte, and that read clears it. A per-source enable word masks which of the latched flags may pull the interrupt line low. The line itself is open drain. The block asserts `irq_oe` to drive the pad low and drops it to let the pull-up release the line.

Two small state machines do the sequencing. The line machine has the states IRQ_IDLE and IRQ_PEND. It takes the transition *raise* (IDLE to PEND) when any enabled flag is pending. It takes the transition *release* (PEND to IDLE) once no enabled flag remains. The thermal machine has the states TH_COOL and TH_HOT. It takes the transition *trip* (COOL to HOT) when the over-threshold input goes high, and this trip is also the overtemperature event. It takes the transition *recover* (HOT to COOL) when the input falls. While the thermal machine is in TH_HOT, the LED drivers are held off.

The power-on flag is set by the asynchronous power-on reset. It is not cleared by the shutdown clear (`soft_clr`) that wipes the other flags, so software can still see that a power-up happened.

Top module: `intr_status_ctrl`

## Requirements
- R1: While `rst_n` is low, and up to the first clock edge after it rises, `stat_byte` is 10h (only the power-on flag, bit 4, is set), `irq_oe` is 0 and `led_drv_off` is 0.
- R2: A pulse on `led_done[i]` sets status bit 5+i at the next clock edge only if enable bit 5+i of `en_word` is 1 in that cycle. Otherwise the status byte is unchanged.
- R3: A pulse on `uvlo_evt` sets status bit 3. The cycle in which `otp_hot` goes from 0 to 1 sets status bit 2. Both flags latch whatever the enable word holds.
- R4: `stat_byte` shows the flags directly. A cycle with `stat_rd` high still shows the value from before the clear. At the clock edge ending that cycle, every flag clears.
- R5: An event that arrives in the same cycle as a read is still set after the read.
- R6: At each edge, `irq_oe` takes the OR of the pending enabled flags. The mask is as follows:
  - bit 4 (power-on) is always enabled;
  - bit 3 is enabled by `en_word[4]`;
  - bit 2 is enabled by `en_word[3]`;
  - bits 7:5 are enabled by `en_word[7:5]`.
  So the line asserts one cycle after a flag is pending and enabled, and releases one cycle after none is left.
- R7: `soft_clr` clears bits 7:5, 3 and 2 at the next edge, and this wins over any new event. Bit 4 keeps its value unless a read clears it in the same cycle.
- R8: `led_drv_off` goes high one edge after `otp_hot` rises and falls one edge after it falls. Holding `otp_hot` high sets bit 2 only once, so a read during a long hot period leaves the bit clear.
- R9: Bits 2:0 of `en_word` have no effect on any output. Status bits 1:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_word | input | 8 | Enable word: bits 7:5 enable the LED done events, bit 4 undervoltage, bit 3 overtemperature, bit 0 chip enable (not used here) |
| led_done | input | 3 | Pattern-done pulses, one per LED channel |
| uvlo_evt | input | 1 | Undervoltage event pulse |
| otp_hot | input | 1 | Over-threshold level from the temperature comparator |
| stat_rd | input | 1 | Read strobe for the status byte (clear on read) |
| soft_clr | input | 1 | Shutdown register clear; keeps the power-on flag |
| stat_byte | output | 8 | Status byte: 7:5 LED done, 4 power-on, 3 undervoltage, 2 overtemperature |
| irq_oe | output | 1 | Drive enable that pulls the open-drain interrupt pad low |
| led_drv_off | output | 1 | Disables the LED drivers while overtemperature is active |

## Verification
Some rules can be checked on every cycle, and the assertions cover them:
- the interrupt line follows the masked OR of the status byte one edge later;
- a flag stays set unless a read or the shutdown clear removes it;
- an undervoltage pulse always leaves its flag set, even during a read;
- the shutdown clear keeps the power-on bit;
- the driver-off output tracks the thermal input with one cycle of lag.

Other behaviour depends on a particular order of events, so only the bench scenarios can show it:
- the power-on flag surviving a shutdown clear and then being cleared by a later read;
- a done event being dropped because its enable was off at the moment it fired;
- a long hot period setting its flag only once;
- the low enable bits having no effect.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;

    typedef enum logic {
        TH_COOL = 1'b0,
        TH_HOT  = 1'b1
    } therm_state_t;

    localparam int unsigned STAT_W       = 8;
    localparam int unsigned LED_FLAG_LSB = 5;
    localparam int unsigned POR_BIT      = 4;
    localparam int unsigned UV_BIT       = 3;
    localparam int unsigned OT_BIT       = 2;
    localparam int unsigned LED_EN_LSB   = 5;
    localparam int unsigned UV_EN_BIT    = 4;
    localparam int unsigned OT_EN_BIT    = 3;

endpackage

// File: rtl/intr_flag_cell.sv
module intr_flag_cell #(
    parameter bit KEEP_ON_SOFT = 1'b0,
    parameter bit RESET_VAL    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic rd_clr,
    input  logic set_evt,
    output logic flag_q
);

    // Priority: shutdown clear, then a new event, then the read clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= RESET_VAL;
        end else if (soft_clr && !KEEP_ON_SOFT) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (rd_clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank
    import intr_pkg::*;
#(
    parameter int unsigned NUM_LED = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               stat_rd,
    input  logic [NUM_LED-1:0] led_done,
    input  logic [NUM_LED-1:0] led_en,
    input  logic               uv_evt,
    input  logic               ot_evt,
    output logic [STAT_W-1:0]  stat_byte
);

    logic [NUM_LED-1:0] led_q;
    logic               por_q;
    logic               uv_q;
    logic               ot_q;

    // The LED done events are gated by their enables before they latch.
    for (genvar i = 0; i < NUM_LED; i++) begin : g_led
        intr_flag_cell #(
            .KEEP_ON_SOFT (1'b0),
            .RESET_VAL    (1'b0)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .rd_clr   (stat_rd),
            .set_evt  (led_done[i] & led_en[i]),
            .flag_q   (led_q[i])
        );
    end

    intr_flag_cell #(
        .KEEP_ON_SOFT (1'b1),
        .RESET_VAL    (1'b1)
    ) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .rd_clr   (stat_rd),
        .set_evt  (1'b0),
        .flag_q   (por_q)
    );

    intr_flag_cell #(
        .KEEP_ON_SOFT (1'b0),
        .RESET_VAL    (1'b0)
    ) u_uv (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .rd_clr   (stat_rd),
        .set_evt  (uv_evt),
        .flag_q   (uv_q)
    );

    intr_flag_cell #(
        .KEEP_ON_SOFT (1'b0),
        .RESET_VAL    (1'b0)
    ) u_ot (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .rd_clr   (stat_rd),
        .set_evt  (ot_evt),
        .flag_q   (ot_q)
    );

    always_comb begin
        stat_byte                           = '0;
        stat_byte[LED_FLAG_LSB +: NUM_LED]  = led_q;
        stat_byte[POR_BIT]                  = por_q;
        stat_byte[UV_BIT]                   = uv_q;
        stat_byte[OT_BIT]                   = ot_q;
    end

endmodule

// File: rtl/intr_thermal_fsm.sv
module intr_thermal_fsm
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic otp_hot,
    output logic trip_evt,
    output logic drv_off
);

    therm_state_t state_q;
    therm_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TH_COOL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        trip_evt = 1'b0;
        unique case (state_q)
            TH_COOL: begin
                if (otp_hot) begin
                    state_d  = TH_HOT;   // trip
                    trip_evt = 1'b1;
                end
            end
            TH_HOT: begin
                if (!otp_hot) begin
                    state_d = TH_COOL;   // recover
                end
            end
            default: state_d = TH_COOL;
        endcase
    end

    always_comb begin
        drv_off = (state_q == TH_HOT);
    end

endmodule

// File: rtl/intr_line_fsm.sv
module intr_line_fsm
    import intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    output logic irq_oe
);

    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (pend_any)  state_d = IRQ_PEND;  // raise
            IRQ_PEND: if (!pend_any) state_d = IRQ_IDLE;  // release
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_oe = (state_q == IRQ_PEND);
    end

endmodule

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
    import intr_pkg::*;
#(
    parameter int unsigned NUM_LED = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STAT_W-1:0]  en_word,
    input  logic [NUM_LED-1:0] led_done,
    input  logic               uvlo_evt,
    input  logic               otp_hot,
    input  logic               stat_rd,
    input  logic               soft_clr,
    output logic [STAT_W-1:0]  stat_byte,
    output logic               irq_oe,
    output logic               led_drv_off
);

    logic              ot_trip;
    logic [STAT_W-1:0] irq_mask;
    logic              pend_any;
    logic              unused_en_bits;

    assign unused_en_bits = ^en_word[2:0];

    intr_thermal_fsm u_therm (
        .clk      (clk),
        .rst_n    (rst_n),
        .otp_hot  (otp_hot),
        .trip_evt (ot_trip),
        .drv_off  (led_drv_off)
    );

    intr_flag_bank #(
        .NUM_LED (NUM_LED)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .stat_rd   (stat_rd),
        .led_done  (led_done),
        .led_en    (en_word[LED_EN_LSB +: NUM_LED]),
        .uv_evt    (uvlo_evt),
        .ot_evt    (ot_trip),
        .stat_byte (stat_byte)
    );

    // Enable positions differ from flag positions for the two supply sources.
    always_comb begin
        irq_mask                          = '0;
        irq_mask[LED_FLAG_LSB +: NUM_LED] = en_word[LED_EN_LSB +: NUM_LED];
        irq_mask[POR_BIT]                 = 1'b1;
        irq_mask[UV_BIT]                  = en_word[UV_EN_BIT];
        irq_mask[OT_BIT]                  = en_word[OT_EN_BIT];
        pend_any                          = |(stat_byte & irq_mask);
    end

    intr_line_fsm u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_any (pend_any),
        .irq_oe   (irq_oe)
    );

endmodule

// File: rtl/intr_status_ctrl_chk.sv
module intr_status_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] en_word,
    input logic [2:0] led_done,
    input logic       uvlo_evt,
    input logic       otp_hot,
    input logic       stat_rd,
    input logic       soft_clr,
    input logic [7:0] stat_byte,
    input logic       irq_oe,
    input logic       led_drv_off
);

    logic [7:0] chk_mask;
    logic       chk_pend;

    always_comb begin
        chk_mask = {en_word[7:5], 1'b1, en_word[4], en_word[3], 2'b00};
        chk_pend = |(stat_byte & chk_mask);
    end

    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_pend |=> irq_oe);

    p_irq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_pend |=> !irq_oe);

    p_led2_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte[7] && !stat_rd && !soft_clr) |=> stat_byte[7]);

    p_uv_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_evt && !soft_clr) |=> stat_byte[3]);

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !uvlo_evt) |=> (stat_byte[4:3] == 2'b00));

    p_por_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr && !stat_rd) |=> (stat_byte[4] == $past(stat_byte[4])));

    p_soft_wipes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (stat_byte[7:5] == 3'b000) && (stat_byte[3:2] == 2'b00));

    p_drv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        otp_hot |=> led_drv_off);

    p_drv_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !otp_hot |=> !led_drv_off);

    p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[1:0] == 2'b00);

endmodule

bind intr_status_ctrl intr_status_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_word     (en_word),
    .led_done    (led_done),
    .uvlo_evt    (uvlo_evt),
    .otp_hot     (otp_hot),
    .stat_rd     (stat_rd),
    .soft_clr    (soft_clr),
    .stat_byte   (stat_byte),
    .irq_oe      (irq_oe),
    .led_drv_off (led_drv_off)
);

// File: tb/intr_status_ctrl_tb.sv
module intr_status_ctrl_tb;

    logic       clk;
    logic       rst_n;
    logic [7:0] en_word;
    logic [2:0] led_done;
    logic       uvlo_evt;
    logic       otp_hot;
    logic       stat_rd;
    logic       soft_clr;
    logic [7:0] stat_byte;
    logic       irq_oe;
    logic       led_drv_off;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] stat;
        logic       irq;
        logic       off;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    // Reference state built from the requirements.
    logic [7:0] m_flags;
    logic       m_irq;
    logic       m_hot;

    intr_status_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_word     (en_word),
        .led_done    (led_done),
        .uvlo_evt    (uvlo_evt),
        .otp_hot     (otp_hot),
        .stat_rd     (stat_rd),
        .soft_clr    (soft_clr),
        .stat_byte   (stat_byte),
        .irq_oe      (irq_oe),
        .led_drv_off (led_drv_off)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // One cycle of stimulus plus the expected outputs after its edge.
    task automatic cyc(input logic [2:0] d, input logic uv, input logic hot,
                       input logic rd, input logic sc, input logic [7:0] en,
                       input string req);
        logic [7:0] mask;
        logic [7:0] newf;
        logic [7:0] nf;
        exp_t       e;
        @(negedge clk);
        led_done = d; uvlo_evt = uv; otp_hot = hot;
        stat_rd = rd; soft_clr = sc; en_word = en;
        mask = {en[7:5], 1'b1, en[4], en[3], 2'b00};
        newf = {d & en[7:5], 1'b0, uv, hot & ~m_hot, 2'b00};
        if (sc) nf = {3'b000, (rd ? 1'b0 : m_flags[4]), 4'b0000};
        else    nf = (rd ? 8'h00 : m_flags) | newf;
        m_irq   = |(m_flags & mask);
        m_flags = nf;
        m_hot   = hot;
        e.stat = m_flags; e.irq = m_irq; e.off = m_hot; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compares each expected item just after its clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (stat_byte !== e.stat || irq_oe !== e.irq || led_drv_off !== e.off) begin
                    errors++;
                    $display("FAIL %s: stat=%02h irq=%0b off=%0b expected stat=%02h irq=%0b off=%0b",
                             e.req, stat_byte, irq_oe, led_drv_off, e.stat, e.irq, e.off);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en_word = 8'h00; led_done = 3'b000; uvlo_evt = 1'b0;
        otp_hot = 1'b0; stat_rd = 1'b0; soft_clr = 1'b0;
        m_flags = 8'h10; m_irq = 1'b0; m_hot = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (stat_byte !== 8'h10 || irq_oe !== 1'b0 || led_drv_off !== 1'b0) begin
            errors++;
            $display("FAIL R1: stat=%02h irq=%0b off=%0b expected stat=10 irq=0 off=0",
                     stat_byte, irq_oe, led_drv_off);
        end
        rst_n = 1'b1;

        // R6: power-on flag is always unmasked.
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R6");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R6");
        // R3: undervoltage latches even with enable off.
        cyc(3'b000, 1, 0, 0, 0, 8'h00, "R3");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R3");
        // R7: shutdown clear keeps the power-on bit, wipes the rest.
        cyc(3'b000, 1, 0, 0, 1, 8'h00, "R7");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R7");
        // R4: read clears the power-on flag; line releases.
        cyc(3'b000, 0, 0, 1, 0, 8'h00, "R4");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R4");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R6");
        // R2: disabled LED0 event is ignored, enabled one latches.
        cyc(3'b001, 0, 0, 0, 0, 8'h00, "R2");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R2");
        cyc(3'b001, 0, 0, 0, 0, 8'h20, "R2");
        cyc(3'b000, 0, 0, 0, 0, 8'h20, "R6");
        cyc(3'b000, 0, 0, 0, 0, 8'h20, "R6");
        // R6: mask removal releases the line while the flag stays.
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R6");
        cyc(3'b000, 0, 0, 0, 0, 8'h00, "R6");
        // R2: LED2 and LED1 events with their own enables.
        cyc(3'b100, 0, 0, 0, 0, 8'h80, "R2");
        cyc(3'b010, 0, 0, 0, 0, 8'h40, "R2");
        cyc(3'b000, 0, 0, 0, 0, 8'hE0, "R6");
        // R5: event during the read survives it.
        cyc(3'b010, 0, 0, 1, 0, 8'hE0, "R5");
        cyc(3'b000, 0, 0, 0, 0, 8'hE0, "R5");
        cyc(3'b000, 1, 0, 1, 0, 8'h10, "R5");
        cyc(3'b000, 0, 0, 0, 0, 8'h10, "R6");
        cyc(3'b000, 0, 0, 1, 0, 8'h10, "R4");
        cyc(3'b000, 0, 0, 0, 0, 8'h10, "R4");
        // R8: overtemperature trip, one flag per rise, recovery.
        cyc(3'b000, 0, 1, 0, 0, 8'h08, "R8");
        cyc(3'b000, 0, 1, 0, 0, 8'h08, "R8");
        cyc(3'b000, 0, 1, 1, 0, 8'h08, "R8");
        cyc(3'b000, 0, 1, 0, 0, 8'h08, "R8");
        cyc(3'b000, 0, 1, 0, 0, 8'h08, "R8");
        cyc(3'b000, 0, 0, 0, 0, 8'h08, "R8");
        cyc(3'b000, 0, 0, 0, 0, 8'h08, "R8");
        cyc(3'b000, 0, 1, 0, 0, 8'h00, "R3");
        cyc(3'b000, 0, 0, 1, 0, 8'h00, "R4");
        // R9: low enable bits change nothing.
        cyc(3'b111, 0, 0, 0, 0, 8'h07, "R9");
        cyc(3'b000, 0, 0, 0, 0, 8'h07, "R9");
        cyc(3'b000, 1, 0, 0, 0, 8'h07, "R9");
        cyc(3'b000, 0, 0, 0, 0, 8'h07, "R9");
        cyc(3'b000, 0, 0, 1, 0, 8'hFF, "R6");
        cyc(3'b000, 0, 0, 0, 0, 8'hFF, "R6");
        cyc(3'b000, 0, 0, 0, 0, 8'hFF, "R6");
        @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule